// File: doc/BRIEF.md
# Bitmap Operand Index Sequencer

This block takes one instruction's three architectural register numbers and turns them into a stream of register-index triples (destination, source 1, source 2). Each triple drives one element operation. The block keeps a bank of 32 selection bitmaps. Bit k of a bitmap selects register k. The instruction's destination field, source-1 field and source-2 field each pick one bitmap from the bank.

The destination list is made of the set bits of the destination bitmap, in ascending order. The length of that list is the number of element operations. Each source list is made of the set bits of its own bitmap, also in ascending order. It restarts from its lowest set bit whenever it runs out, and this continues until the destination list is covered. The bank can be written with any value. A read returns the legalised value, which software uses to learn the effective length.

A start pulse launches a sequence. The triples leave on a valid/ready handshake, and a done flag marks the end of the sequence. The element count is reported as soon as the start pulse is accepted. Register reads and writes, the ALU, and the hazard handling that gives all elements parallel semantics (every source read at its value from before the instruction) belong to the surrounding pipeline.

Top module: `bitsel_sequencer`

## Requirements
- R1: After reset, bitmap i holds 1<<i. The read port returns the legalised content of bitmap `map_rsel` one clock after the select is presented.
- R2: A write with `map_we` stores `map_wdata` unchanged into bitmap `map_wsel`. A later read returns that value, except that a stored zero reads back as 1<<i.
- R3: A start pulse is accepted only when the block is idle. From the cycle after acceptance, `op_count` shows the population count of the raw destination bitmap, and it keeps that value until the next accepted start.
- R4: The `out_rd` values are the set-bit positions of the destination bitmap in ascending order. Exactly one triple is emitted per set bit.
- R5: The `out_rs1` and `out_rs2` values walk the set-bit positions of their bitmaps in ascending order. Each list restarts from its lowest set bit after its highest one.
- R6: A source bitmap that holds zero is used as 1<<field, where field is the instruction field that selected it.
- R7: If the destination bitmap is zero, no triple is emitted. `done` is high for exactly the one cycle after the accepting edge.
- R8: While `out_valid` is high and `out_ready` is low, `out_rd`, `out_rs1`, `out_rs2` and `done` hold their values.
- R9: `done` is high together with the last triple of a sequence and low with every earlier triple.
- R10: With `out_ready` held high, the triples of a sequence of n elements are accepted on n consecutive clocks.
- R11: A start pulse during a running sequence is ignored. A bitmap write during a running sequence does not change that sequence, but it is stored.
- R12: With the reset bitmaps, an instruction with fields (d, a, b) produces the single triple (d, a, b) with `done` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_we | input | 1 | Bitmap write enable |
| map_wsel | input | 5 | Bitmap number to write |
| map_wdata | input | 32 | Value to write |
| map_rsel | input | 5 | Bitmap number to read |
| map_rdata | output | 32 | Legalised bitmap content, registered |
| start | input | 1 | Launch a sequence for the given fields |
| fld_rd | input | 5 | Destination field, selects destination bitmap |
| fld_rs1 | input | 5 | Source-1 field, selects source-1 bitmap |
| fld_rs2 | input | 5 | Source-2 field, selects source-2 bitmap |
| op_count | output | 6 | Element count of the accepted instruction |
| out_valid | output | 1 | Triple valid |
| out_ready | input | 1 | Consumer accepts the triple |
| out_rd | output | 5 | Destination register index |
| out_rs1 | output | 5 | Source-1 register index |
| out_rs2 | output | 5 | Source-2 register index |
| done | output | 1 | Last triple present, or empty sequence finished |

## Verification
The reset bitmaps give single scalar triples, so the field-to-bitmap mapping is checked without any wrap-around. The worked case pairs a five-bit destination with a three-bit and a one-bit source. That separates correct cyclic repetition from clamping and from plain index counting. A full 32-bit destination against sparse sources that include bit 31 shows whether the wrap point is found correctly at both ends of the word. Zero destination and zero source maps check the empty sequence and the substitution of the one-hot default. Random ready patterns and a start/write pair issued mid-run check that the stream holds under stalls and that the captured operands are isolated from later activity.

// File: rtl/bitsel_pkg.sv
package bitsel_pkg;
  typedef enum logic {W_IDLE, W_RUN} walk_state_t;
endpackage

// File: rtl/bitsel_lowbit.sv
module bitsel_lowbit #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic [W-1:0]  rest
);
  // Lowest set bit wins: scan downwards so the last hit is the lowest.
  always_comb begin
    idx = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (vec[k]) idx = IW'(k);
    end
  end

  assign rest = vec & (vec - W'(1));
endmodule

// File: rtl/bitsel_popcnt.sv
module bitsel_popcnt #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int k = 0; k < W; k++) cnt = cnt + CW'(vec[k]);
  end
endmodule

// File: rtl/bitsel_bank.sv
module bitsel_bank #(
  parameter int NREG = 32,
  parameter int IW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IW-1:0]   wsel,
  input  logic [NREG-1:0] wdata,
  input  logic [IW-1:0]   rsel,
  output logic [NREG-1:0] rdata,
  input  logic [IW-1:0]   sel_d,
  input  logic [IW-1:0]   sel_a,
  input  logic [IW-1:0]   sel_b,
  output logic [NREG-1:0] map_d,
  output logic [NREG-1:0] map_a,
  output logic [NREG-1:0] map_b
);
  logic [NREG-1:0] maps  [NREG];
  logic [NREG-1:0] legal [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREG; k++) maps[k] <= NREG'(1) << k;
    end else if (we) begin
      maps[wsel] <= wdata;
    end
  end

  // Legal view: an empty map reads as its one-hot default.
  for (genvar g = 0; g < NREG; g++) begin : g_legal
    assign legal[g] = (maps[g] == '0) ? (NREG'(1) << g) : maps[g];

    assert_reset_map_R1: assert property (@(posedge clk)
      rst |=> maps[g] == (NREG'(1) << g));
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= legal[rsel];
  end

  // Destination uses the raw map (zero means no elements); sources use the legal view.
  assign map_d = maps[sel_d];
  assign map_a = legal[sel_a];
  assign map_b = legal[sel_b];

  assert_read_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> maps[$past(wsel)] == $past(wdata));
endmodule

// File: rtl/bitsel_walker.sv
module bitsel_walker #(
  parameter int NREG = 32,
  parameter int IW   = $clog2(NREG),
  parameter int CW   = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [NREG-1:0] map_d,
  input  logic [NREG-1:0] map_a,
  input  logic [NREG-1:0] map_b,
  output logic [CW-1:0]   op_count,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [IW-1:0]   out_rd,
  output logic [IW-1:0]   out_rs1,
  output logic [IW-1:0]   out_rs2,
  output logic            done
);
  import bitsel_pkg::*;

  walk_state_t     st;
  logic [NREG-1:0] dw, aw, bw, a_orig, b_orig;
  logic [NREG-1:0] d_rest, a_rest, b_rest;
  logic [IW-1:0]   d_idx, a_idx, b_idx;
  logic [CW-1:0]   pc;
  logic            idle, take, adv;

  bitsel_lowbit #(.W(NREG), .IW(IW)) u_pick_d (.vec(dw), .idx(d_idx), .rest(d_rest));
  bitsel_lowbit #(.W(NREG), .IW(IW)) u_pick_a (.vec(aw), .idx(a_idx), .rest(a_rest));
  bitsel_lowbit #(.W(NREG), .IW(IW)) u_pick_b (.vec(bw), .idx(b_idx), .rest(b_rest));
  bitsel_popcnt #(.W(NREG), .CW(CW)) u_count  (.vec(map_d), .cnt(pc));

  assign idle = (st == W_IDLE) && !out_valid;
  assign take = start && idle;
  assign adv  = (st == W_RUN) && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= W_IDLE;
      dw        <= '0;
      aw        <= '0;
      bw        <= '0;
      a_orig    <= '0;
      b_orig    <= '0;
      op_count  <= '0;
      out_valid <= 1'b0;
      out_rd    <= '0;
      out_rs1   <= '0;
      out_rs2   <= '0;
      done      <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (done && (!out_valid || out_ready)) done <= 1'b0;
      if (take) begin
        op_count <= pc;
        dw       <= map_d;
        aw       <= map_a;
        bw       <= map_b;
        a_orig   <= map_a;
        b_orig   <= map_b;
        if (map_d == '0) done <= 1'b1;
        else             st   <= W_RUN;
      end
      if (adv) begin
        out_valid <= 1'b1;
        out_rd    <= d_idx;
        out_rs1   <= a_idx;
        out_rs2   <= b_idx;
        dw        <= d_rest;
        aw        <= (a_rest == '0) ? a_orig : a_rest;
        bw        <= (b_rest == '0) ? b_orig : b_rest;
        if (d_rest == '0) begin
          done <= 1'b1;
          st   <= W_IDLE;
        end
      end
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_rd) && $stable(out_rs1)
                                && $stable(out_rs2) && $stable(done));

  assert_empty_dest_R7: assert property (@(posedge clk) disable iff (rst)
    take && (map_d == '0) |=> done && !out_valid);

  assert_src_legal_R6: assert property (@(posedge clk) disable iff (rst)
    (st == W_RUN) |-> (aw != '0) && (bw != '0));

  assert_last_ends_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && done |=> !out_valid);

  assert_busy_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    (st == W_RUN) |-> op_count != '0);
endmodule

// File: rtl/bitsel_sequencer.sv
module bitsel_sequencer #(
  parameter int NREG = 32,
  parameter int IW   = $clog2(NREG),
  parameter int CW   = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            map_we,
  input  logic [IW-1:0]   map_wsel,
  input  logic [NREG-1:0] map_wdata,
  input  logic [IW-1:0]   map_rsel,
  output logic [NREG-1:0] map_rdata,
  input  logic            start,
  input  logic [IW-1:0]   fld_rd,
  input  logic [IW-1:0]   fld_rs1,
  input  logic [IW-1:0]   fld_rs2,
  output logic [CW-1:0]   op_count,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [IW-1:0]   out_rd,
  output logic [IW-1:0]   out_rs1,
  output logic [IW-1:0]   out_rs2,
  output logic            done
);
  logic [NREG-1:0] map_d, map_a, map_b;

  bitsel_bank #(.NREG(NREG), .IW(IW)) u_bank (
    .clk(clk), .rst(rst),
    .we(map_we), .wsel(map_wsel), .wdata(map_wdata),
    .rsel(map_rsel), .rdata(map_rdata),
    .sel_d(fld_rd), .sel_a(fld_rs1), .sel_b(fld_rs2),
    .map_d(map_d), .map_a(map_a), .map_b(map_b)
  );

  bitsel_walker #(.NREG(NREG), .IW(IW), .CW(CW)) u_walk (
    .clk(clk), .rst(rst), .start(start),
    .map_d(map_d), .map_a(map_a), .map_b(map_b),
    .op_count(op_count),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2),
    .done(done)
  );
endmodule

// File: tb/bitsel_sequencer_test.sv
module bitsel_sequencer_test;
  localparam int PERIOD = 10;
  localparam int WDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        map_we = 1'b0;
  logic [4:0]  map_wsel = '0;
  logic [31:0] map_wdata = '0;
  logic [4:0]  map_rsel = '0;
  logic [31:0] map_rdata;
  logic        start = 1'b0;
  logic [4:0]  fld_rd = '0, fld_rs1 = '0, fld_rs2 = '0;
  logic [5:0]  op_count;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [4:0]  out_rd, out_rs1, out_rs2;
  logic        done;

  bitsel_sequencer uut (
    .clk(clk), .rst(rst), .map_we(map_we), .map_wsel(map_wsel), .map_wdata(map_wdata),
    .map_rsel(map_rsel), .map_rdata(map_rdata), .start(start),
    .fld_rd(fld_rd), .fld_rs1(fld_rs1), .fld_rs2(fld_rs2), .op_count(op_count),
    .out_valid(out_valid), .out_ready(out_ready), .out_rd(out_rd),
    .out_rs1(out_rs1), .out_rs2(out_rs2), .done(done)
  );

  always #(PERIOD / 2) clk = ~clk;

  int          vectors = 0, fails = 0, cyc = 0;
  int          hs_cnt = 0, first_hs = 0, last_hs = 0;
  int          rdy_mode = 0;
  logic [15:0] exp_q[$];
  logic [31:0] model [32];
  logic [7:0]  lfsr = 8'hA5;
  logic        prev_stall = 1'b0;
  logic [15:0] stall_snap = '0;
  bit          reported = 0;

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Ready pattern generator.
  always @(posedge clk) begin
    #1;
    if (rdy_mode == 0) out_ready = 1'b1;
    else begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = lfsr[0] | lfsr[2];
    end
  end

  // Monitor: scoreboard compare and stall-hold check.
  always @(negedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
      report();
    end
    if (!rst) begin
      if (prev_stall) chk("R8 hold", {out_valid, done, out_rd, out_rs1, out_rs2}, {1'b1, stall_snap});
      prev_stall = out_valid && !out_ready;
      stall_snap = {done, out_rd, out_rs1, out_rs2};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk("R4 unexpected triple", {out_rd, out_rs1, out_rs2}, 64'hDEAD);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk("R4 rd", out_rd, e[14:10]);
          chk("R5 rs1", out_rs1, e[9:5]);
          chk("R5 rs2", out_rs2, e[4:0]);
          chk("R9 done", done, e[15]);
        end
        if (hs_cnt == 0) first_hs = cyc;
        last_hs = cyc;
        hs_cnt++;
      end
    end
  end

  task automatic wr(input int sel, input logic [31:0] d);
    @(posedge clk); #1;
    map_we = 1'b1; map_wsel = 5'(sel); map_wdata = d;
    @(posedge clk); #1;
    map_we = 1'b0;
    model[sel] = d;
  endtask

  task automatic rd_chk(input int sel, input logic [31:0] exp, input string req);
    @(posedge clk); #1;
    map_rsel = 5'(sel);
    @(negedge clk); @(negedge clk);
    chk(req, map_rdata, exp);
  endtask

  // Driver: computes expected triples from the bench model, then launches.
  task automatic exec(input int d, input int a, input int b, input bit interfere);
    logic [31:0] dm, am, bm;
    int dl[$], al[$], bl[$];
    int n;
    dm = model[d];
    am = (model[a] == 0) ? (32'd1 << a) : model[a];
    bm = (model[b] == 0) ? (32'd1 << b) : model[b];
    for (int k = 0; k < 32; k++) begin
      if (dm[k]) dl.push_back(k);
      if (am[k]) al.push_back(k);
      if (bm[k]) bl.push_back(k);
    end
    n = dl.size();
    for (int i = 0; i < n; i++)
      exp_q.push_back({(i == n - 1), 5'(dl[i]), 5'(al[i % al.size()]), 5'(bl[i % bl.size()])});
    hs_cnt = 0;
    @(posedge clk); #1;
    start = 1'b1; fld_rd = 5'(d); fld_rs1 = 5'(a); fld_rs2 = 5'(b);
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk("R3 op_count", op_count, n);
    if (n == 0) begin
      chk("R7 done after empty start", {done, out_valid}, 2'b10);
      @(negedge clk);
      chk("R7 done one cycle", {done, out_valid}, 2'b00);
    end else begin
      if (interfere) begin
        @(posedge clk); #1;
        start = 1'b1; fld_rd = 5'd1; fld_rs1 = 5'd2; fld_rs2 = 5'd3;
        map_we = 1'b1; map_wsel = 5'(a); map_wdata = 32'h5;
        @(posedge clk); #1;
        start = 1'b0; map_we = 1'b0;
        model[a] = 32'h5;
      end
      while (exp_q.size() != 0 || out_valid) @(negedge clk);
      repeat (4) @(negedge clk);
      chk("R4 count", hs_cnt, n);
      if (rdy_mode == 0) chk("R10 back-to-back", last_hs - first_hs, n - 1);
      if (interfere) chk("R11 ignored start keeps count", op_count, n);
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 32'd1 << i;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 reset outputs", {out_valid, done}, 2'b00);
    rd_chk(5, 32'h20, "R1 reset map 5");
    rd_chk(31, 32'h8000_0000, "R1 reset map 31");

    // R12: scalar default.
    exec(7, 3, 9, 0);

    // Worked example: R4, R5.
    wr(1, 32'b011111); wr(2, 32'b1011); wr(3, 32'b00010);
    exec(1, 2, 3, 0);
    rd_chk(2, 32'b1011, "R2 readback");

    // R6: zero source map.
    wr(4, 32'h0);
    rd_chk(4, 32'h10, "R2 zero reads default");
    exec(1, 4, 3, 0);

    // R7: zero destination.
    wr(10, 32'h0);
    exec(10, 2, 3, 0);

    // Full destination, sparse wrapping sources.
    wr(20, 32'hFFFF_FFFF); wr(21, 32'h8000_0001); wr(22, 32'h00F0_0000);
    exec(20, 21, 22, 0);
    rdy_mode = 1;
    exec(20, 22, 21, 0);

    // R11: start and write during a run.
    exec(20, 21, 22, 1);
    rd_chk(21, 32'h5, "R11 write stored");

    // Assorted patterns under random ready.
    wr(11, 32'h1234_5678); wr(12, 32'h0000_0300); wr(13, 32'hC000_0003);
    exec(11, 12, 13, 0);
    exec(13, 11, 12, 0);
    rdy_mode = 0;
    exec(11, 13, 4, 0);

    report();
  end
endmodule